// File: doc/BRIEF.md
# NAND Bus Width Access Adapter

This block converts host register accesses of one, two or four bytes into a series of device bus cycles on an asynchronous NAND-style flash bus whose data path is either 8 or 16 bits wide. Each chip select owns a 16-byte window holding three registers: a command register, an address register and a data register. Writing the command register produces command-latch cycles, writing the address register produces address-latch cycles, and reading or writing the data register produces plain data cycles.

The host presents a request together with direction, address, access size and write data, and holds all of them until the block returns a one-cycle ready pulse. Ready comes only after the last device cycle has finished, so one access is in flight at a time. Each device cycle keeps the read or write strobe low for a parameterized number of clocks, followed by one recovery clock. Bytes are always ordered little-endian. The lowest byte or halfword moves first.

Per chip select, a configuration input marks the device as NAND-type, and a 2-bit width code selects the bus width. Accesses to a chip select that is not NAND-type complete with no device activity.

Top module: `nand_width_adapter`

## Requirements
- R1: On an 8-bit device (width code bit 0 = 0), a data access of size code 0 (1 byte) makes one device cycle, size code 1 (2 bytes) makes two, and size code 2 (4 bytes) makes four. Cycle k carries byte k of the host word on data bits 7:0, so the least significant byte goes first. Write cycles drive 0 on bits 15:8, and reads ignore bits 15:8.
- R2: On a 16-bit device (width code bit 0 = 1), size codes 0 and 1 make one device cycle and size code 2 makes two. Cycle k carries halfword k of the host word, so the lower halfword goes first.
- R3: A 1-byte read from a 16-bit device makes exactly one device read and returns only bits 7:0 of the device bus. Bits 31:8 of the read data are zero.
- R4: A 1-byte write to a 16-bit device is accepted and makes one device write that drives host write data bits 15:0 onto the bus.
- R5: Writes to the command register raise the command latch (dev_cle) and keep dev_ale low. Writes to the address register raise dev_ale and keep dev_cle low. Data register cycles raise neither. The command and address registers are write-only: reading them returns 0 and makes no device cycle.
- R6: Host address bits [CS_W+3:4] select the chip select. Bits 3:2 select the register: 0 is command, 1 is address, 2 is data, and 3 is reserved. A reserved-register access reads 0 and makes no device cycle. Address bits 1:0 have no effect.
- R7: Only bit 0 of a chip select's 2-bit width code is used. Codes 2 and 3 behave exactly like codes 0 and 1.
- R8: When a chip select's NAND-type input is 0, reads of its window return 0 and writes make no device cycle. Ready is still returned.
- R9: host_ready is a single-cycle pulse that comes after the last recovery clock of the access, or after two clocks for an access with no device cycles. While cycles run, only the addressed chip select's dev_cs_n is low, and all are high otherwise.
- R10: Each device cycle holds its strobe (dev_re_n for reads, dev_we_n for writes) low for exactly STROBE_CLKS clocks, then high for at least one clock.
- R11: Size code 3 behaves as a 4-byte access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | Access request, held with its fields until host_ready |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | CS_W+4 | Chip select, register and byte offset |
| host_size | input | 2 | Access size code: 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data, valid while host_ready is high |
| host_ready | output | 1 | One-cycle completion pulse |
| cs_is_nand | input | NUM_CS | Per chip select: device is NAND-type |
| cs_width | input | 2*NUM_CS | Per chip select 2-bit width code; bit 0 = 16-bit |
| dev_cs_n | output | NUM_CS | Active-low chip selects |
| dev_cle | output | 1 | Command latch enable |
| dev_ale | output | 1 | Address latch enable |
| dev_re_n | output | 1 | Active-low read strobe |
| dev_we_n | output | 1 | Active-low write strobe |
| dev_dq_out | output | 16 | Device write data |
| dev_dq_oe | output | 1 | Drive enable for dev_dq_out |
| dev_dq_in | input | 16 | Device read data |

## Verification
Some properties are checked by assertions on every clock. The latch strobes never rise together and never accompany a read. At most one chip select is active, and a non-NAND chip select is never selected. Ready never lasts two cycles. A 1-byte read never returns upper bits. Every strobe pulse is exactly STROBE_CLKS clocks long.

Other properties can only be shown by the bench sweep. It covers every chip select, register, byte offset, size code, direction and width code. It checks the number of device cycles, their byte and halfword order and the driven data, and it checks the read data assembled from a counting device model.

// File: rtl/nwa_pkg.sv
package nwa_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_STRB = 2'd1,
        ST_RECV = 2'd2,
        ST_DONE = 2'd3
    } seq_state_e;

    // Register select inside a chip-select window; the encoding is decoded from address bits 3:2
    typedef enum logic [1:0] {
        RK_CMD  = 2'd0,
        RK_ADDR = 2'd1,
        RK_DATA = 2'd2,
        RK_RSVD = 2'd3
    } reg_kind_e;

    // Index of the final device cycle for a given bus width and size code
    function automatic logic [1:0] last_beat_f(input logic wide, input logic [1:0] size);
        logic [1:0] r;
        if (wide)           r = size[1] ? 2'd1 : 2'd0;
        else if (size[1])   r = 2'd3;
        else if (size[0])   r = 2'd1;
        else                r = 2'd0;
        return r;
    endfunction

    function automatic logic [31:0] size_mask_f(input logic [1:0] size);
        logic [31:0] m;
        if (size[1])      m = 32'hFFFF_FFFF;
        else if (size[0]) m = 32'h0000_FFFF;
        else              m = 32'h0000_00FF;
        return m;
    endfunction

endpackage

// File: rtl/nwa_decode.sv
module nwa_decode
    import nwa_pkg::*;
#(
    parameter int NUM_CS = 4,
    parameter int CS_W   = 2
) (
    input  logic [CS_W+3:0]    addr,
    input  logic               we,
    input  logic [1:0]         size,
    input  logic [NUM_CS-1:0]  cs_is_nand,
    input  logic [2*NUM_CS-1:0] cs_width,
    output logic [CS_W-1:0]    cs_idx,
    output reg_kind_e          kind,
    output logic               wide,
    output logic [1:0]         last_beat,
    output logic               go
);

    logic [NUM_CS-1:0] wide_vec;
    logic [NUM_CS-1:0] width_hi_unused_vec;
    logic              addr_lo_unused;
    logic              cs_in_range;
    logic              is_nand;

    // Only the low bit of each width code is honoured (R7)
    for (genvar g = 0; g < NUM_CS; g++) begin : g_width
        assign wide_vec[g]            = cs_width[2*g];
        assign width_hi_unused_vec[g] = cs_width[2*g+1];
    end

    // Byte offset inside a register has no effect (R6)
    assign addr_lo_unused = ^addr[1:0] ^ (^width_hi_unused_vec);

    always_comb begin
        cs_idx      = addr[CS_W+3:4];
        kind        = reg_kind_e'(addr[3:2]);
        cs_in_range = (32'(cs_idx) < NUM_CS);
        is_nand     = cs_in_range && cs_is_nand[cs_idx];
        wide        = cs_in_range && wide_vec[cs_idx];
        last_beat   = last_beat_f(wide, size);
        // Command/address registers are write-only; reserved slot never runs
        go          = is_nand && ((kind == RK_DATA) ||
                                  (we && (kind != RK_RSVD)));
    end

endmodule

// File: rtl/nwa_lane.sv
module nwa_lane (
    input  logic        wide,
    input  logic [1:0]  beat,
    input  logic [31:0] wdata,
    input  logic [15:0] dq_in,
    input  logic [31:0] acc,
    output logic [15:0] dq_out,
    output logic [31:0] acc_next
);

    always_comb begin
        acc_next = acc;
        if (wide) begin
            // Halfword lanes, lower half first (R2, R4)
            dq_out = beat[0] ? wdata[31:16] : wdata[15:0];
            if (beat[0]) acc_next[31:16] = dq_in;
            else         acc_next[15:0]  = dq_in;
        end else begin
            // Byte lanes, least significant first (R1)
            dq_out = {8'h00, wdata[{beat, 3'b000} +: 8]};
            acc_next[{beat, 3'b000} +: 8] = dq_in[7:0];
        end
    end

endmodule

// File: rtl/nwa_seq.sv
module nwa_seq
    import nwa_pkg::*;
#(
    parameter int NUM_CS      = 4,
    parameter int CS_W        = 2,
    parameter int STROBE_CLKS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              we,
    input  logic [1:0]        size,
    input  logic [31:0]       wdata,
    input  logic [CS_W-1:0]   dec_cs,
    input  reg_kind_e         dec_kind,
    input  logic              dec_wide,
    input  logic [1:0]        dec_last,
    input  logic              dec_go,
    input  logic [31:0]       acc_next,
    output logic              ready,
    output logic [31:0]       rdata,
    output logic [1:0]        beat,
    output logic              wide,
    output logic [31:0]       wdata_q,
    output logic [31:0]       acc,
    output logic [NUM_CS-1:0] dev_cs_n,
    output logic              dev_cle,
    output logic              dev_ale,
    output logic              dev_re_n,
    output logic              dev_we_n,
    output logic              dev_dq_oe
);

    localparam int CNT_W = (STROBE_CLKS > 1) ? $clog2(STROBE_CLKS) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STROBE_CLKS - 1);
    localparam int RUN_W = CNT_W + 1;

    typedef struct packed {
        seq_state_e       st;
        logic [1:0]       beat;
        logic [CNT_W-1:0] cnt;
        logic [CS_W-1:0]  cs;
        reg_kind_e        kind;
        logic             wr;
        logic             wide;
        logic [1:0]       last;
        logic [1:0]       size;
        logic [31:0]      wdata;
        logic [31:0]      acc;
        logic [31:0]      rdata;
    } seq_t;

    seq_t seq_d, seq_q;
    logic active;

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.st)
            ST_IDLE: begin
                if (req) begin
                    seq_d.cs    = dec_cs;
                    seq_d.kind  = dec_kind;
                    seq_d.wr    = we;
                    seq_d.wide  = dec_wide;
                    seq_d.last  = dec_last;
                    seq_d.size  = size;
                    seq_d.wdata = wdata;
                    seq_d.acc   = '0;
                    seq_d.beat  = '0;
                    seq_d.cnt   = '0;
                    if (dec_go) begin
                        seq_d.st = ST_STRB;
                    end else begin
                        seq_d.rdata = '0;
                        seq_d.st    = ST_DONE;
                    end
                end
            end
            ST_STRB: begin
                if (seq_q.cnt == CNT_LAST) begin
                    // Sample read data on the last strobe-low clock
                    if (!seq_q.wr) seq_d.acc = acc_next;
                    seq_d.st = ST_RECV;
                end else begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end
            ST_RECV: begin
                if (seq_q.beat == seq_q.last) begin
                    seq_d.rdata = seq_q.wr ? 32'h0 : (seq_q.acc & size_mask_f(seq_q.size));
                    seq_d.st    = ST_DONE;
                end else begin
                    seq_d.beat = seq_q.beat + 1'b1;
                    seq_d.cnt  = '0;
                    seq_d.st   = ST_STRB;
                end
            end
            ST_DONE: seq_d.st = ST_IDLE;
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    always_comb begin
        active    = (seq_q.st == ST_STRB) || (seq_q.st == ST_RECV);
        ready     = (seq_q.st == ST_DONE);
        rdata     = seq_q.rdata;
        beat      = seq_q.beat;
        wide      = seq_q.wide;
        wdata_q   = seq_q.wdata;
        acc       = seq_q.acc;
        dev_cs_n  = active ? ~(NUM_CS'(1) << seq_q.cs) : '1;
        dev_cle   = active && seq_q.wr && (seq_q.kind == RK_CMD);
        dev_ale   = active && seq_q.wr && (seq_q.kind == RK_ADDR);
        dev_re_n  = !((seq_q.st == ST_STRB) && !seq_q.wr);
        dev_we_n  = !((seq_q.st == ST_STRB) && seq_q.wr);
        dev_dq_oe = active && seq_q.wr;
    end

    // Length of the current strobe-low run, for the width checks below
    logic [RUN_W-1:0] low_run;
    logic             strobe_low;
    assign strobe_low = !dev_re_n || !dev_we_n;

    always_ff @(posedge clk) begin
        if (!rst_n)          low_run <= '0;
        else if (strobe_low) low_run <= low_run + 1'b1;
        else                 low_run <= '0;
    end

    AST_STROBE_NOT_LONG: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_low |-> (low_run < RUN_W'(STROBE_CLKS))) else $error("strobe too long"); // R10

    AST_STROBE_NOT_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe_low && $past(strobe_low)) |-> ($past(low_run) == RUN_W'(STROBE_CLKS - 1)))
        else $error("strobe too short"); // R10

    AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> !ready) else $error("ready longer than one cycle"); // R9

endmodule

// File: rtl/nand_width_adapter.sv
module nand_width_adapter
    import nwa_pkg::*;
#(
    parameter int NUM_CS      = 4,
    parameter int STROBE_CLKS = 2,
    localparam int CS_W       = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
    localparam int ADDR_W     = CS_W + 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                host_req,
    input  logic                host_we,
    input  logic [ADDR_W-1:0]   host_addr,
    input  logic [1:0]          host_size,
    input  logic [31:0]         host_wdata,
    output logic [31:0]         host_rdata,
    output logic                host_ready,
    input  logic [NUM_CS-1:0]   cs_is_nand,
    input  logic [2*NUM_CS-1:0] cs_width,
    output logic [NUM_CS-1:0]   dev_cs_n,
    output logic                dev_cle,
    output logic                dev_ale,
    output logic                dev_re_n,
    output logic                dev_we_n,
    output logic [15:0]         dev_dq_out,
    output logic                dev_dq_oe,
    input  logic [15:0]         dev_dq_in
);

    logic [CS_W-1:0] dec_cs;
    reg_kind_e       dec_kind;
    logic            dec_wide;
    logic [1:0]      dec_last;
    logic            dec_go;
    logic [1:0]      beat;
    logic            wide_q;
    logic [31:0]     wdata_q;
    logic [31:0]     acc;
    logic [31:0]     acc_next;

    nwa_decode #(.NUM_CS(NUM_CS), .CS_W(CS_W)) decode_i (
        .addr       (host_addr),
        .we         (host_we),
        .size       (host_size),
        .cs_is_nand (cs_is_nand),
        .cs_width   (cs_width),
        .cs_idx     (dec_cs),
        .kind       (dec_kind),
        .wide       (dec_wide),
        .last_beat  (dec_last),
        .go         (dec_go)
    );

    nwa_seq #(.NUM_CS(NUM_CS), .CS_W(CS_W), .STROBE_CLKS(STROBE_CLKS)) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (host_req),
        .we        (host_we),
        .size      (host_size),
        .wdata     (host_wdata),
        .dec_cs    (dec_cs),
        .dec_kind  (dec_kind),
        .dec_wide  (dec_wide),
        .dec_last  (dec_last),
        .dec_go    (dec_go),
        .acc_next  (acc_next),
        .ready     (host_ready),
        .rdata     (host_rdata),
        .beat      (beat),
        .wide      (wide_q),
        .wdata_q   (wdata_q),
        .acc       (acc),
        .dev_cs_n  (dev_cs_n),
        .dev_cle   (dev_cle),
        .dev_ale   (dev_ale),
        .dev_re_n  (dev_re_n),
        .dev_we_n  (dev_we_n),
        .dev_dq_oe (dev_dq_oe)
    );

    nwa_lane lane_i (
        .wide     (wide_q),
        .beat     (beat),
        .wdata    (wdata_q),
        .dq_in    (dev_dq_in),
        .acc      (acc),
        .dq_out   (dev_dq_out),
        .acc_next (acc_next)
    );

    AST_LATCH_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(dev_cle && dev_ale)) else $error("cle and ale together"); // R5

    AST_LATCH_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_cle || dev_ale) |-> dev_re_n) else $error("latch strobe on read"); // R5

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_re_n || dev_we_n)) else $error("read and write strobes together"); // R10

    AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~dev_cs_n)) else $error("several chip selects"); // R9

    AST_NONNAND_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ((~dev_cs_n & ~cs_is_nand) == '0)) else $error("non-NAND select active"); // R8

    AST_NARROW_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (host_ready && host_req && !host_we && (host_size == 2'd0)) |-> (host_rdata[31:8] == 24'h0))
        else $error("1-byte read returned upper bits"); // R3

endmodule

// File: tb/nand_width_adapter_tb.sv
module nand_width_adapter_tb_top;

    localparam int NUM_CS      = 4;
    localparam int STROBE_CLKS = 2;
    localparam int ADDR_W      = 6;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                host_req = 1'b0;
    logic                host_we = 1'b0;
    logic [ADDR_W-1:0]   host_addr = '0;
    logic [1:0]          host_size = '0;
    logic [31:0]         host_wdata = '0;
    logic [31:0]         host_rdata;
    logic                host_ready;
    logic [NUM_CS-1:0]   cs_is_nand = 4'b1101;
    logic [2*NUM_CS-1:0] cs_width = '0;
    logic [NUM_CS-1:0]   dev_cs_n;
    logic                dev_cle, dev_ale, dev_re_n, dev_we_n, dev_dq_oe;
    logic [15:0]         dev_dq_out;
    logic [15:0]         dev_dq_in;

    always #4 clk = ~clk;

    nand_width_adapter #(.NUM_CS(NUM_CS), .STROBE_CLKS(STROBE_CLKS)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .host_req(host_req), .host_we(host_we), .host_addr(host_addr),
        .host_size(host_size), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .host_ready(host_ready),
        .cs_is_nand(cs_is_nand), .cs_width(cs_width),
        .dev_cs_n(dev_cs_n), .dev_cle(dev_cle), .dev_ale(dev_ale),
        .dev_re_n(dev_re_n), .dev_we_n(dev_we_n),
        .dev_dq_out(dev_dq_out), .dev_dq_oe(dev_dq_oe), .dev_dq_in(dev_dq_in)
    );

    int checks = 0;
    int errors = 0;

    function automatic logic [15:0] pat(input int k);
        logic [7:0] hi, lo;
        hi = 8'(8'h91 + 7 * k);
        lo = 8'(8'h25 + 13 * k);
        return {hi, lo};
    endfunction

    // Device model: read data advances after each completed read strobe
    int rd_idx = 0;
    assign dev_dq_in = pat(rd_idx);

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Bus monitor, sampled on the falling clock edge
    int         nrec = 0;
    logic [15:0] rec_dq   [8];
    logic        rec_cle  [8];
    logic        rec_ale  [8];
    logic        rec_wr   [8];
    logic [3:0]  rec_cs   [8];
    bit          prev_strobe = 1'b0;
    bit          prev_re_low = 1'b0;
    int          low_len = 0;

    always @(negedge clk) begin
        bit strobe;
        strobe = !dev_re_n || !dev_we_n;
        if (strobe && !prev_strobe) begin
            if (nrec < 8) begin
                rec_dq[nrec]  = dev_dq_out;
                rec_cle[nrec] = dev_cle;
                rec_ale[nrec] = dev_ale;
                rec_wr[nrec]  = !dev_we_n;
                rec_cs[nrec]  = dev_cs_n;
            end
            nrec++;
        end
        if (strobe) low_len++;
        else if (prev_strobe) begin
            chk(low_len == STROBE_CLKS, "R10 strobe width", 32'(low_len), 32'(STROBE_CLKS));
            low_len = 0;
        end
        if (dev_re_n && prev_re_low) rd_idx++;
        prev_re_low = !dev_re_n;
        prev_strobe = strobe;
    end

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    task automatic do_op(input int cs, input int rg, input int off, input int sz,
                         input bit wr, input logic [31:0] wd, input int code);
        int          start, waited, nb;
        bit          valid, wide;
        logic [31:0] got, exp, mask;
        string       tag;
        @(negedge clk);
        nrec       = 0;
        start      = rd_idx;
        host_addr  = ADDR_W'((cs << 4) | (rg << 2) | off);
        host_size  = 2'(sz);
        host_we    = wr;
        host_wdata = wd;
        host_req   = 1'b1;
        waited     = 0;
        do begin
            @(negedge clk);
            waited++;
        end while (!host_ready && waited < 200);
        got      = host_rdata;
        host_req = 1'b0;
        chk(host_ready == 1'b1, "R9 ready arrives", 32'(host_ready), 32'd1);
        @(negedge clk);
        chk(host_ready == 1'b0, "R9 ready single pulse", 32'(host_ready), 32'd0);

        valid = cs_is_nand[cs] && (rg == 2 || (wr && rg != 3));
        wide  = code[0];
        if (!valid)    nb = 0;
        else if (wide) nb = (sz >= 2) ? 2 : 1;
        else           nb = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;

        if (!valid)                  tag = "R8";
        else if (wide && sz == 0)    tag = wr ? "R4" : "R3";
        else if (wide)               tag = "R2";
        else                         tag = "R1";
        if (rg != 2)  tag = {tag, " R5"};
        if (off != 0) tag = {tag, " R6"};
        if (code >= 2) tag = {tag, " R7"};
        if (sz == 3)  tag = {tag, " R11"};

        chk(nrec == nb, {tag, " cycle count"}, 32'(nrec), 32'(nb));
        for (int k = 0; k < nb && k < nrec && k < 8; k++) begin
            chk(rec_cs[k] == ~(4'b0001 << cs), {tag, " R9 chip select"}, 32'(rec_cs[k]), 32'(~(4'b0001 << cs)));
            chk(rec_wr[k] == wr, {tag, " direction"}, 32'(rec_wr[k]), 32'(wr));
            chk(rec_cle[k] == (wr && rg == 0) && rec_ale[k] == (wr && rg == 1),
                {tag, " R5 latch strobes"}, {30'h0, rec_cle[k], rec_ale[k]},
                {30'h0, 1'(wr && rg == 0), 1'(wr && rg == 1)});
            if (wr) begin
                logic [15:0] e;
                e = wide ? wd[16*k +: 16] : {8'h00, wd[8*k +: 8]};
                chk(rec_dq[k] == e, {tag, " write data"}, 32'(rec_dq[k]), 32'(e));
            end
        end
        if (!wr) begin
            exp = 32'h0;
            for (int k = 0; k < nb; k++) begin
                if (wide) exp[16*k +: 16] = pat(start + k);
                else      exp[8*k +: 8]   = pat(start + k)[7:0];
            end
            mask = (sz >= 2) ? 32'hFFFF_FFFF : (sz == 1) ? 32'h0000_FFFF : 32'h0000_00FF;
            exp  = exp & mask;
            chk(got == exp, {tag, " read data"}, got, exp);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        int opn;
        repeat (3) @(negedge clk);
        // Reset state: all device strobes idle, no ready (R9)
        chk(host_ready == 1'b0 && dev_cs_n == 4'hF, "R9 reset idle", {27'h0, host_ready, dev_cs_n}, 32'h0000_000F);
        chk(dev_re_n && dev_we_n && !dev_cle && !dev_ale && !dev_dq_oe, "R10 reset strobes",
            {27'h0, dev_re_n, dev_we_n, dev_cle, dev_ale, dev_dq_oe}, 32'h18);
        rst_n = 1'b1;
        opn = 0;
        // Sweep width code (R7), chip select (R8), register (R5, R6), offset (R6), size (R1 R2 R11), direction
        for (int code = 0; code < 4; code++) begin
            cs_width = {4{2'(code)}};
            for (int cs = 0; cs < NUM_CS; cs++)
                for (int rg = 0; rg < 4; rg++)
                    for (int off = 0; off < 4; off++)
                        for (int sz = 0; sz < 4; sz++)
                            for (int wr = 0; wr < 2; wr++) begin
                                do_op(cs, rg, off, sz, 1'(wr), 32'hC3A5_1E69 ^ (32'(opn) * 32'h0101_0103), code);
                                opn++;
                            end
        end
        summary();
        $finish;
    end

endmodule